// File: doc/BRIEF.md
# DRAM Page-Hit Wait-State Generator

This block sits in a memory controller and decides, for each DRAM access, whether the access falls in the page that is already open. It keeps the row part of the address of the most recent access and compares the incoming row against it. It then counts out the wait states that apply: a short count for a page hit and a longer one for a page miss. The column width is programmable, so the bit where row and column meet moves with a two-bit size field.

Access requests arrive as a one-cycle strobe with an address. The block raises `busy` for the number of wait states, then pulses `ready` for one cycle. A strobe that arrives while `busy` is high is dropped. A page-invalidate input, used after a refresh, forgets the stored row so that the next access is a miss. Generating the DRAM strobes is left to other logic.

Top module: `dram_page_wait`

## Requirements
- R1: After reset, `hit`, `busy` and `ready` are 0, and the stored row is invalid, so the first access is a miss.
- R2: `page_sz` selects the column width: 0 gives 9 bits, 1 gives 10, 2 gives 11 and 3 gives 12. Address bits at and above the column width form the row. Bits below it never affect the hit decision.
- R3: On a page hit the wait count is `inpage_ws` + 1, which gives 1, 2, 3 or 4 for codes 0 to 3.
- R4: On a page miss the wait count is 4, 8, 11 or 15 for `outpage_ws` codes 0, 1, 2 and 3.
- R5: An access is a hit only when `page_en` is 1, the stored row is valid and the row bits match. With `page_en` at 0, `hit` is 0 and the miss count applies.
- R6: An access is accepted at a rising edge where `acc_start` is 1 and `busy` is 0. `busy` is then 1 for exactly N cycles, starting in the cycle after that edge. `ready` is 1 for the single cycle that follows, with `busy` at 0.
- R7: An `acc_start` that arrives while `busy` is 1 has no effect. The running count, `hit` and the stored row are left unchanged.
- R8: Every accepted access stores its row and marks it valid. A `page_inval` pulse clears the valid mark. If `page_inval` arrives in the same cycle as an accepted access, the valid mark ends cleared.
- R9: `hit` is registered when an access is accepted and holds its value until the next accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_start | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Access address |
| page_en | input | 1 | Enables page-hit detection |
| page_sz | input | 2 | Column width select |
| inpage_ws | input | 2 | Wait-state code for a page hit |
| outpage_ws | input | 2 | Wait-state code for a page miss |
| page_inval | input | 1 | Clears the stored row's valid mark |
| hit | output | 1 | Registered page-hit flag for the last accepted access |
| busy | output | 1 | High while wait states are counted |
| ready | output | 1 | One-cycle pulse when the wait count ends |

## Verification
The hardest case to reach is a strobe that arrives in the middle of a count and carries a different row. If the design wrongly accepted it, the count would restart and the open page would be overwritten. The bench injects such a strobe during a long miss count, with only the top address bit flipped. It then checks that the count length is unchanged and that the next access to the original row still hits. Invalidation in the same cycle as an accepted access is driven once on its own. The row split is probed with addresses that flip either the top column bit or the lowest row bit, for every page size.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

  localparam int MIN_COL = 9;
  localparam int MAX_COL = 12;
  localparam int WS_W    = 4;

  typedef logic [WS_W-1:0] ws_t;

  function automatic ws_t near_waits(input logic [1:0] code);
    return ws_t'(code) + ws_t'(1);
  endfunction

  function automatic ws_t far_waits(input logic [1:0] code);
    ws_t w;
    case (code)
      2'd0:    w = ws_t'(4);
      2'd1:    w = ws_t'(8);
      2'd2:    w = ws_t'(11);
      default: w = ws_t'(15);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/dpw_rst_sync.sv
module dpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dpw_row_tracker.sv
module dpw_row_tracker
  import dpw_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int ROW_W = ADDR_W - MIN_COL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             invalidate,
  input  logic             page_en,
  input  logic [1:0]       col_sel,
  input  logic [ROW_W-1:0] addr_row,
  output logic             hit_now
);
  logic [ROW_W-1:0] row_q, row_d;
  logic             vld_q, vld_d;
  logic [ROW_W-1:0] bit_diff;

  // Bit i of the row field is compared only when it lies above the column width
  for (genvar i = 0; i < ROW_W; i++) begin : g_cmp
    logic active;
    if (i >= MAX_COL - MIN_COL) begin : g_always
      assign active = 1'b1;
    end else begin : g_sel
      assign active = (col_sel <= 2'(i));
    end
    assign bit_diff[i] = active & (addr_row[i] ^ row_q[i]);
  end

  always_comb hit_now = page_en & vld_q & ~(|bit_diff);

  always_comb begin
    row_d = row_q;
    vld_d = vld_q;
    if (capture) begin
      row_d = addr_row;
      vld_d = 1'b1;
    end
    if (invalidate) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else begin
      row_q <= row_d;
      vld_q <= vld_d;
    end
  end
endmodule

// File: rtl/dpw_wait_select.sv
module dpw_wait_select
  import dpw_pkg::*;
(
  input  logic       page_hit,
  input  logic [1:0] near_code,
  input  logic [1:0] far_code,
  output ws_t        waits
);
  always_comb waits = page_hit ? near_waits(near_code) : far_waits(far_code);
endmodule

// File: rtl/dpw_wait_timer.sv
module dpw_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)        cnt_d = load_val;
    else if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
    rdy_d = ~load & (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign busy  = (cnt_q != '0);
  assign ready = rdy_q;
endmodule

// File: rtl/dram_page_wait.sv
module dram_page_wait
  import dpw_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              page_en,
  input  logic [1:0]        page_sz,
  input  logic [1:0]        inpage_ws,
  input  logic [1:0]        outpage_ws,
  input  logic              page_inval,
  output logic              hit,
  output logic              busy,
  output logic              ready
);
  localparam int ROW_W = ADDR_W - MIN_COL;

  logic rst_i_n;
  logic accept;
  logic hit_now;
  logic hit_q, hit_d;
  ws_t  waits;
  logic unused_low_addr;

  assign unused_low_addr = ^acc_addr[MIN_COL-1:0];

  dpw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb accept = acc_start & ~busy;

  dpw_row_tracker #(.ADDR_W(ADDR_W)) u_row (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .capture    (accept),
    .invalidate (page_inval),
    .page_en    (page_en),
    .col_sel    (page_sz),
    .addr_row   (acc_addr[ADDR_W-1:MIN_COL]),
    .hit_now    (hit_now)
  );

  dpw_wait_select u_sel (
    .page_hit  (hit_now),
    .near_code (inpage_ws),
    .far_code  (outpage_ws),
    .waits     (waits)
  );

  dpw_wait_timer #(.CNT_W(WS_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (accept),
    .load_val (waits),
    .busy     (busy),
    .ready    (ready)
  );

  always_comb hit_d = accept ? hit_now : hit_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    hit_q <= 1'b0;
    else if (accept) hit_q <= hit_d;
  end

  assign hit = hit_q;

  if (ROW_W < 4) begin : g_bad_width
    initial $error("ADDR_W too small for a 12-bit column");
  end
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic page_en,
  input logic page_inval,
  input logic hit,
  input logic busy,
  input logic ready
);
  logic       inval_seen;
  logic [4:0] run_len;
  logic       acc_ok;

  assign acc_ok = acc_start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_seen <= 1'b1;
      run_len    <= '0;
    end else begin
      if (page_inval)  inval_seen <= 1'b1;
      else if (acc_ok) inval_seen <= 1'b0;
      if (!busy)                run_len <= '0;
      else if (run_len != 5'd31) run_len <= run_len + 5'd1;
    end
  end

  a_r6_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);
  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r6_busy_end_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ready);
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> busy);
  a_r4_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 5'd15);
  a_r5_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !page_en) |=> !hit);
  a_r8_inval_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && inval_seen) |=> !hit);
  a_r9_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> $stable(hit));
endmodule

bind dram_page_wait dpw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_start  (acc_start),
  .page_en    (page_en),
  .page_inval (page_inval),
  .hit        (hit),
  .busy       (busy),
  .ready      (ready)
);

// File: tb/sim_dram_page_wait.sv
module sim_dram_page_wait;
  localparam int AW  = 16;
  localparam int TCK = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_start;
  logic [AW-1:0] acc_addr;
  logic          page_en;
  logic [1:0]    page_sz, inpage_ws, outpage_ws;
  logic          page_inval;
  logic          hit, busy, ready;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  dram_page_wait #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_addr(acc_addr),
    .page_en(page_en), .page_sz(page_sz), .inpage_ws(inpage_ws),
    .outpage_ws(outpage_ws), .page_inval(page_inval),
    .hit(hit), .busy(busy), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_waits(input bit h);
    int far;
    far = (outpage_ws == 2'd0) ? 4 : (outpage_ws == 2'd1) ? 8 :
          (outpage_ws == 2'd2) ? 11 : 15;
    return h ? int'(inpage_ws) + 1 : far;
  endfunction

  task automatic inval_pulse();
    @(negedge clk); page_inval = 1'b1;
    @(negedge clk); page_inval = 1'b0;
  endtask

  // One access: strobe, then count busy cycles and check the ready pulse
  task automatic do_acc(input logic [AW-1:0] a, input bit eh, input bit poke,
                        input bit inv_same, input string req);
    int n, en;
    bit hit0;
    en = exp_waits(eh);
    @(negedge clk);
    acc_start = 1'b1; acc_addr = a; page_inval = inv_same;
    @(negedge clk);
    acc_start = 1'b0; page_inval = 1'b0;
    check(hit == eh, req, int'(hit), int'(eh));
    check(busy == 1'b1, "R6 busy rises", int'(busy), 1);
    hit0 = hit;
    n = 0;
    while (busy && n < 40) begin
      n++;
      if (poke && n == 2) begin
        acc_start = 1'b1;
        acc_addr  = a ^ AW'(1 << (AW-1));
      end else acc_start = 1'b0;
      @(negedge clk);
    end
    acc_start = 1'b0;
    // R3 / R4 / R6 / R7: wait length
    check(n == en, eh ? "R3 in-page length" : "R4 out-of-page length", n, en);
    check(ready == 1'b1, "R6 ready after busy", int'(ready), 1);
    check(hit == hit0, "R9 hit held", int'(hit), int'(hit0));
    @(negedge clk);
    check(ready == 1'b0, "R6 ready one cycle", int'(ready), 0);
  endtask

  initial begin
    rst_n = 1'b0; acc_start = 1'b0; acc_addr = '0; page_en = 1'b0;
    page_sz = 2'd0; inpage_ws = 2'd0; outpage_ws = 2'd0; page_inval = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(hit == 1'b0,   "R1 hit reset",   int'(hit), 0);
    check(busy == 1'b0,  "R1 busy reset",  int'(busy), 0);
    check(ready == 1'b0, "R1 ready reset", int'(ready), 0);
    page_en = 1'b1; outpage_ws = 2'd1;
    do_acc(AW'(16'h0a00), 1'b0, 1'b0, 1'b0, "R1 first access misses");

    for (int cfg = 0; cfg < 128; cfg++) begin
      int colw, r;
      logic [AW-1:0] a, b, d, e;
      bit pe;
      page_sz    = cfg[1:0];
      inpage_ws  = cfg[3:2];
      outpage_ws = cfg[5:4];
      pe         = cfg[6];
      page_en    = pe;
      colw = 9 + int'(page_sz);
      r    = 2 + cfg % 5;
      a = AW'((r << colw) | 3);
      b = AW'((r << colw) | ((1 << colw) - 1));
      d = a ^ AW'(1 << (colw - 1));
      e = a ^ AW'(1 << colw);
      inval_pulse();
      do_acc(a, 1'b0, 1'b0, 1'b0, "R8 miss after invalidate");
      do_acc(b, pe,   1'b0, 1'b0, "R2 same page low bits");
      do_acc(d, pe,   1'b0, 1'b0, "R2 top column bit ignored");
      do_acc(e, 1'b0, 1'b0, 1'b0, "R2 lowest row bit compared");
      do_acc(e, pe,   1'b1, 1'b0, "R5 repeat row hit");
      do_acc(e, pe,   1'b0, 1'b0, "R7 row kept after dropped strobe");
      inval_pulse();
      do_acc(e, 1'b0, 1'b0, 1'b0, "R8 invalidate forces miss");
    end

    // R8: invalidate in the same cycle as an accepted access
    page_en = 1'b1; page_sz = 2'd2; inpage_ws = 2'd1; outpage_ws = 2'd2;
    do_acc(AW'(16'h3000), 1'b0, 1'b0, 1'b0, "R8 prime row");
    do_acc(AW'(16'h3004), 1'b1, 1'b0, 1'b1, "R8 same-cycle access hits");
    do_acc(AW'(16'h3008), 1'b0, 1'b0, 1'b0, "R8 valid cleared by same-cycle invalidate");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule